// File: doc/BRIEF.md
# Compare Output Waveform Generator

This block produces the waveform on one compare output pin of a 16-bit timer channel. A separate counter supplies the count value, the count direction and strobes that flag the BOTTOM and TOP ticks. A timer-clock enable marks the clock cycles in which the counter advances. The generator compares the count with the channel's compare value. On a match it emits a one-cycle pulse and, as selected by a 2-bit output-mode field and a 4-bit waveform mode, it sets, clears or toggles the pin level.

The waveform mode falls into one of four families:

- non-PWM: codes 0, 4 and 12.
- single-slope (fast) PWM: codes 5, 6, 7, 14 and 15.
- dual-slope PWM: codes 1, 2, 3, 8, 9, 10 and 11.
- reserved: code 13.

The meaning of the output-mode field depends on the family. A channel identity input, with code 00 for A, 01 for B and 10 for C, limits where toggling is allowed. A forced-compare strobe lets software apply the selected action at once, but only in the non-PWM family.

Top module: `cmp_wavegen`

## Requirements
- R1: While reset is asserted and after it is released, `pin_level` is 0 and `match_pulse` is 0 until an action or a match occurs.
- R2: `pin_override` is 1 exactly when `out_mode` is nonzero. The one exception is `out_mode` 01 where toggling is not permitted, which gives 0. Toggling is permitted in the non-PWM family for every channel. In fast PWM it is permitted for channel A (code 00) with waveform mode 15 only. In dual-slope PWM it is permitted for channel A with waveform mode 9 or 11 only. In the reserved code it is never permitted.
- R3: `match_pulse` is 1 for the single clock cycle that follows a cycle with `tick` high and `cnt_val` equal to `cmp_val`. A forced compare never raises it.
- R4: In the non-PWM family, a match on a tick acts on the pin in the next cycle as set by `out_mode`: 01 inverts the pin, 10 drives it 0 and 11 drives it 1.
- R5: In fast PWM, a match on a tick drives the pin 0 under `out_mode` 10 and 1 under `out_mode` 11. A tick with `at_bottom` high drives the opposite level. When both fall on the same tick, the match action wins.
- R6: In fast PWM with `out_mode[1]` set, a match on a tick that also has `at_top` high is ignored, so the compare value equals TOP. Only the BOTTOM action then moves the pin.
- R7: Under `out_mode` 01, a permitted match toggles the pin in fast and dual-slope PWM. Where toggling is not permitted (see R2), a match leaves the pin unchanged.
- R8: In dual-slope PWM, a match on a tick drives the pin 0 while counting up and 1 while counting down (`cnt_down` 1) under `out_mode` 10. Under `out_mode` 11 it does the reverse.
- R9: In the non-PWM family, `force_cmp` applies the R4 action in the next cycle even without a tick. A forced compare and a ticked match in the same cycle produce a single action.
- R10: In the PWM families and the reserved code, `force_cmp` leaves the pin unchanged.
- R11: In a cycle with neither `tick` nor an effective `force_cmp`, the pin level does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer-clock enable; the counter advances in this cycle |
| cnt_val | input | 16 | Current counter value |
| cnt_down | input | 1 | 1 while the counter is counting down |
| at_top | input | 1 | The counter is at TOP in this tick |
| at_bottom | input | 1 | The counter is at BOTTOM in this tick |
| cmp_val | input | 16 | Compare value of this channel |
| out_mode | input | 2 | Output action selector |
| wave_mode | input | 4 | Waveform mode code |
| chan_sel | input | 2 | Channel identity: 00 A, 01 B, 10 C |
| force_cmp | input | 1 | Forced-compare strobe |
| pin_level | output | 1 | Compare output level |
| pin_override | output | 1 | 1 when the pin is taken from normal port use |
| match_pulse | output | 1 | One-cycle compare-match pulse |

## Verification
Two events can meet in one tick. In fast PWM, a match can coincide with BOTTOM when the compare value is zero. In the non-PWM family, a forced compare can arrive in the same cycle as a ticked match. Directed vectors set up both cases: the fast-PWM case must end at the match level, and the non-PWM toggle case must invert the pin only once. Random vectors raise the match, BOTTOM, TOP and force inputs together often, and each result is compared with a reference model in the bench.

// File: rtl/cowg_pkg.sv
package cowg_pkg;

  localparam int WM_W   = 4;
  localparam int OM_W   = 2;
  localparam int CHAN_W = 2;

  localparam logic [CHAN_W-1:0] CHAN_A = 2'b00;

  typedef enum logic [1:0] {
    FAM_NONPWM = 2'd0,
    FAM_FAST   = 2'd1,
    FAM_DUAL   = 2'd2,
    FAM_RSVD   = 2'd3
  } wave_fam_e;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_CLR  = 2'd1,
    ACT_SET  = 2'd2,
    ACT_TOG  = 2'd3
  } pin_act_e;

  function automatic wave_fam_e classify(input logic [WM_W-1:0] wm);
    wave_fam_e f;
    case (wm)
      4'd0, 4'd4, 4'd12:                        f = FAM_NONPWM;
      4'd5, 4'd6, 4'd7, 4'd14, 4'd15:           f = FAM_FAST;
      4'd1, 4'd2, 4'd3, 4'd8, 4'd9, 4'd10, 4'd11: f = FAM_DUAL;
      default:                                  f = FAM_RSVD;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/cowg_mode_decode.sv
module cowg_mode_decode
  import cowg_pkg::*;
(
  input  logic [WM_W-1:0]   wave_mode,
  input  logic [OM_W-1:0]   out_mode,
  input  logic [CHAN_W-1:0] chan_sel,
  output wave_fam_e         fam,
  output logic              toggle_ok,
  output logic              override
);

  logic is_chan_a;

  always_comb begin
    fam       = classify(wave_mode);
    is_chan_a = (chan_sel == CHAN_A);
    unique case (fam)
      FAM_NONPWM: toggle_ok = 1'b1;
      FAM_FAST:   toggle_ok = is_chan_a && (wave_mode == 4'd15);
      FAM_DUAL:   toggle_ok = is_chan_a && ((wave_mode == 4'd9) || (wave_mode == 4'd11));
      default:    toggle_ok = 1'b0;
    endcase
    override = (out_mode != 2'b00) && !((out_mode == 2'b01) && !toggle_ok);
  end

  // R2
  always_comb begin
    override_zero_chk: assert (!(override && (out_mode == 2'b00)));
  end

endmodule

// File: rtl/cowg_match_unit.sv
module cowg_match_unit #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] cmp_val,
  output logic             hit,
  output logic             match_pulse
);

  logic pulse_d;
  logic pulse_q;

  always_comb begin
    hit     = (cnt_val == cmp_val);
    pulse_d = tick && hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  assign match_pulse = pulse_q;

  // R3
  pulse_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> $past(tick));

  // R3
  pulse_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (cnt_val == cmp_val)) |=> match_pulse);

endmodule

// File: rtl/cowg_pin_ctrl.sv
module cowg_pin_ctrl
  import cowg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            hit,
  input  logic            at_top,
  input  logic            at_bottom,
  input  logic            cnt_down,
  input  logic            force_cmp,
  input  logic [OM_W-1:0] out_mode,
  input  wave_fam_e       fam,
  input  logic            toggle_ok,
  output logic            pin_level
);

  pin_act_e act;
  logic     match_live;
  logic     pin_d;
  logic     pin_en;
  logic     pin_q;

  // next-state: pick one action per cycle
  always_comb begin
    act        = ACT_HOLD;
    match_live = hit && !(out_mode[1] && at_top);
    unique case (fam)
      FAM_NONPWM: begin
        if (force_cmp || (tick && hit)) begin
          case (out_mode)
            2'b01:   act = ACT_TOG;
            2'b10:   act = ACT_CLR;
            2'b11:   act = ACT_SET;
            default: act = ACT_HOLD;
          endcase
        end
      end
      FAM_FAST: begin
        if (tick) begin
          if (match_live) begin
            case (out_mode)
              2'b01:   act = toggle_ok ? ACT_TOG : ACT_HOLD;
              2'b10:   act = ACT_CLR;
              2'b11:   act = ACT_SET;
              default: act = ACT_HOLD;
            endcase
          end else if (at_bottom) begin
            case (out_mode)
              2'b10:   act = ACT_SET;
              2'b11:   act = ACT_CLR;
              default: act = ACT_HOLD;
            endcase
          end
        end
      end
      FAM_DUAL: begin
        if (tick && hit) begin
          case (out_mode)
            2'b01:   act = toggle_ok ? ACT_TOG : ACT_HOLD;
            2'b10:   act = cnt_down ? ACT_SET : ACT_CLR;
            2'b11:   act = cnt_down ? ACT_CLR : ACT_SET;
            default: act = ACT_HOLD;
          endcase
        end
      end
      default: act = ACT_HOLD;
    endcase

    pin_en = (act != ACT_HOLD);
    unique case (act)
      ACT_CLR: pin_d = 1'b0;
      ACT_SET: pin_d = 1'b1;
      ACT_TOG: pin_d = !pin_q;
      default: pin_d = pin_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pin_q <= 1'b0;
    else if (pin_en) pin_q <= pin_d;
  end

  assign pin_level = pin_q;

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !(force_cmp && (fam == FAM_NONPWM))) |=> $stable(pin_level));

  // R10
  pwm_force_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && force_cmp && (fam != FAM_NONPWM)) |=> $stable(pin_level));

  // R4
  nonpwm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fam == FAM_NONPWM) && (out_mode == 2'b11) && (force_cmp || (tick && hit))) |=> pin_level);

  // R6
  top_match_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fam == FAM_FAST) && out_mode[1] && tick && hit && at_top && !at_bottom)
      |=> $stable(pin_level));

  // R8
  dual_down_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fam == FAM_DUAL) && (out_mode == 2'b10) && tick && hit && cnt_down) |=> pin_level);

endmodule

// File: rtl/cmp_wavegen.sv
module cmp_wavegen
  import cowg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_down,
  input  logic             at_top,
  input  logic             at_bottom,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic [1:0]       out_mode,
  input  logic [3:0]       wave_mode,
  input  logic [1:0]       chan_sel,
  input  logic             force_cmp,
  output logic             pin_level,
  output logic             pin_override,
  output logic             match_pulse
);

  logic      rst_meta_q;
  logic      rst_sync_q;
  wave_fam_e fam;
  logic      toggle_ok;
  logic      hit;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  cowg_mode_decode u_decode (
    .wave_mode (wave_mode),
    .out_mode  (out_mode),
    .chan_sel  (chan_sel),
    .fam       (fam),
    .toggle_ok (toggle_ok),
    .override  (pin_override)
  );

  cowg_match_unit #(.CNT_W(CNT_W)) u_match (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .tick        (tick),
    .cnt_val     (cnt_val),
    .cmp_val     (cmp_val),
    .hit         (hit),
    .match_pulse (match_pulse)
  );

  cowg_pin_ctrl u_pin (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .tick      (tick),
    .hit       (hit),
    .at_top    (at_top),
    .at_bottom (at_bottom),
    .cnt_down  (cnt_down),
    .force_cmp (force_cmp),
    .out_mode  (out_mode),
    .fam       (fam),
    .toggle_ok (toggle_ok),
    .pin_level (pin_level)
  );

  // R1
  reset_level_chk: assert property (@(posedge clk)
    !rst_sync_q |-> (!pin_level && !match_pulse));

endmodule

// File: tb/cmp_wavegen_tb_top.sv
module cmp_wavegen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick, cnt_down, at_top, at_bottom, force_cmp;
  logic [15:0] cnt_val, cmp_val;
  logic [1:0]  out_mode, chan_sel;
  logic [3:0]  wave_mode;
  logic        pin_level, pin_override, match_pulse;

  int n_vec  = 0;
  int n_fail = 0;
  logic model_pin = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cmp_wavegen dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_val(cnt_val), .cnt_down(cnt_down),
    .at_top(at_top), .at_bottom(at_bottom), .cmp_val(cmp_val), .out_mode(out_mode),
    .wave_mode(wave_mode), .chan_sel(chan_sel), .force_cmp(force_cmp),
    .pin_level(pin_level), .pin_override(pin_override), .match_pulse(match_pulse)
  );

  // 0 non-PWM, 1 fast, 2 dual, 3 reserved
  function automatic int fam_of(input logic [3:0] wm);
    if (wm == 0 || wm == 4 || wm == 12) return 0;
    if (wm == 5 || wm == 6 || wm == 7 || wm == 14 || wm == 15) return 1;
    if (wm == 13) return 3;
    return 2;
  endfunction

  function automatic bit tog_allowed(input logic [3:0] wm, input logic [1:0] ch);
    case (fam_of(wm))
      0: return 1'b1;
      1: return (ch == 2'b00) && (wm == 15);
      2: return (ch == 2'b00) && (wm == 9 || wm == 11);
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic exp_override(input logic [3:0] wm, input logic [1:0] om,
                                        input logic [1:0] ch);
    if (om == 2'b00) return 1'b0;
    if (om == 2'b01) return tog_allowed(wm, ch);
    return 1'b1;
  endfunction

  function automatic logic next_pin(input logic p, input logic [3:0] wm, input logic [1:0] om,
                                    input logic [1:0] ch, input bit hit, input logic tk,
                                    input logic bot, input logic top, input logic dn,
                                    input logic frc);
    int f = fam_of(wm);
    if (f == 0) begin
      if (frc || (tk && hit)) begin
        if (om == 2'b01) return !p;
        if (om == 2'b10) return 1'b0;
        if (om == 2'b11) return 1'b1;
      end
      return p;
    end
    if (!tk) return p;
    if (f == 1) begin
      if (hit && !(om[1] && top)) begin
        if (om == 2'b01) return tog_allowed(wm, ch) ? !p : p;
        if (om == 2'b10) return 1'b0;
        if (om == 2'b11) return 1'b1;
        return p;
      end
      if (bot) begin
        if (om == 2'b10) return 1'b1;
        if (om == 2'b11) return 1'b0;
      end
      return p;
    end
    if (f == 2 && hit) begin
      if (om == 2'b01) return tog_allowed(wm, ch) ? !p : p;
      if (om == 2'b10) return dn;
      if (om == 2'b11) return !dn;
    end
    return p;
  endfunction

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  // exp_p: -1 use reference model, else hand-computed pin level
  task automatic apply(input logic [3:0] wm, input logic [1:0] om, input logic [1:0] ch,
                       input logic [15:0] cv, input logic [15:0] cmpv, input logic tk,
                       input logic bot, input logic top, input logic dn, input logic frc,
                       input int exp_p, input string tag);
    logic ep;
    logic epul;
    wave_mode = wm; out_mode = om; chan_sel = ch; cnt_val = cv; cmp_val = cmpv;
    tick = tk; at_bottom = bot; at_top = top; cnt_down = dn; force_cmp = frc;
    #1;
    check("R2", "override", pin_override, exp_override(wm, om, ch));
    ep   = (exp_p < 0) ? next_pin(model_pin, wm, om, ch, (cv == cmpv), tk, bot, top, dn, frc)
                       : logic'(exp_p[0]);
    epul = tk && (cv == cmpv);
    @(posedge clk);
    @(negedge clk);
    model_pin = ep;
    check(tag, "pin_level", pin_level, ep);
    check("R3", "match_pulse", match_pulse, epul);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed_ret;
    seed_ret = $urandom(32'h5EED_0042);
    rst_n = 1'b0; tick = 0; cnt_val = 0; cnt_down = 0; at_top = 0; at_bottom = 0;
    cmp_val = 16'h0005; out_mode = 0; wave_mode = 0; chan_sel = 0; force_cmp = 0;
    repeat (3) @(negedge clk);
    check("R1", "pin_level in reset", pin_level, 1'b0);
    check("R1", "match_pulse in reset", match_pulse, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "pin_level after reset", pin_level, 1'b0);

    // R4 non-PWM toggle on a ticked match, channel B
    apply(4'd4, 2'b01, 2'b01, 16'h0010, 16'h0010, 1, 0, 0, 0, 0, 1, "R4");
    // R11 no tick, match present: hold, no pulse
    apply(4'd4, 2'b01, 2'b01, 16'h0010, 16'h0010, 0, 0, 0, 0, 0, 1, "R11");
    // R9 forced compare together with ticked match: single toggle
    apply(4'd0, 2'b01, 2'b00, 16'h0020, 16'h0020, 1, 0, 0, 0, 1, 0, "R9");
    // R9 forced set without tick
    apply(4'd12, 2'b11, 2'b10, 16'h0001, 16'h0002, 0, 0, 0, 0, 1, 1, "R9");
    // R4 clear on match
    apply(4'd0, 2'b10, 2'b00, 16'h0033, 16'h0033, 1, 0, 0, 0, 0, 0, "R4");
    // R5 fast PWM non-inverting: BOTTOM sets, match clears, coincident -> match wins
    apply(4'd14, 2'b10, 2'b01, 16'h0000, 16'h0040, 1, 1, 0, 0, 0, 1, "R5");
    apply(4'd14, 2'b10, 2'b01, 16'h0040, 16'h0040, 1, 0, 0, 0, 0, 0, "R5");
    apply(4'd14, 2'b10, 2'b01, 16'h0000, 16'h0000, 1, 1, 0, 0, 0, 0, "R5");
    // R6 inverting, compare equals TOP: match ignored, then BOTTOM clears
    apply(4'd5, 2'b11, 2'b00, 16'h0000, 16'h00FF, 1, 1, 0, 0, 0, 0, "R5");
    apply(4'd5, 2'b11, 2'b00, 16'h00FF, 16'h00FF, 1, 0, 1, 0, 0, 0, "R6");
    apply(4'd5, 2'b11, 2'b00, 16'h0080, 16'h0080, 1, 0, 0, 0, 0, 1, "R6");
    apply(4'd5, 2'b11, 2'b00, 16'h00FF, 16'h0080, 1, 0, 1, 0, 0, 1, "R6");
    apply(4'd5, 2'b11, 2'b00, 16'h0000, 16'h0080, 1, 1, 0, 0, 0, 0, "R6");
    // R7 toggle legality
    apply(4'd15, 2'b01, 2'b01, 16'h0007, 16'h0007, 1, 0, 0, 0, 0, 0, "R7");
    apply(4'd15, 2'b01, 2'b00, 16'h0007, 16'h0007, 1, 0, 0, 0, 0, 1, "R7");
    apply(4'd10, 2'b01, 2'b00, 16'h0007, 16'h0007, 1, 0, 0, 0, 0, 1, "R7");
    apply(4'd9, 2'b01, 2'b00, 16'h0007, 16'h0007, 1, 0, 0, 1, 0, 0, "R7");
    // R8 dual-slope by direction
    apply(4'd11, 2'b10, 2'b10, 16'h0100, 16'h0100, 1, 0, 0, 1, 0, 1, "R8");
    apply(4'd11, 2'b10, 2'b10, 16'h0100, 16'h0100, 1, 0, 0, 0, 0, 0, "R8");
    apply(4'd1, 2'b11, 2'b01, 16'h0010, 16'h0010, 1, 0, 0, 0, 0, 1, "R8");
    // R10 force ignored in PWM and reserved
    apply(4'd14, 2'b10, 2'b00, 16'h0001, 16'h0002, 0, 0, 0, 0, 1, 1, "R10");
    apply(4'd13, 2'b10, 2'b00, 16'h0002, 16'h0002, 1, 0, 0, 0, 1, 1, "R10");

    for (int i = 0; i < 3000; i++) begin
      logic [3:0]  wm;
      logic [1:0]  om, ch;
      logic [15:0] cmpv, cv;
      logic        tk, bot, top, dn, frc;
      string       tg;
      wm   = 4'($urandom % 16);
      om   = 2'($urandom % 4);
      ch   = 2'($urandom % 3);
      cmpv = 16'($urandom);
      cv   = ($urandom % 3 == 0) ? 16'($urandom) : cmpv;
      tk   = ($urandom % 4 != 0);
      bot  = ($urandom % 4 == 0);
      top  = ($urandom % 4 == 0);
      dn   = 1'($urandom % 2);
      frc  = ($urandom % 5 == 0);
      case (fam_of(wm))
        0: tg = frc ? "R9" : "R4";
        1: tg = top ? "R6" : "R5";
        2: tg = (om == 2'b01) ? "R7" : "R8";
        default: tg = "R10";
      endcase
      apply(wm, om, ch, cv, cmpv, tk, bot, top, dn, frc, -1, tg);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule